// File: doc/BRIEF.md
# Two-Tier Idle Power-Down Timer

This block decides when the peripherals of a multi-function I/O controller, and then the controller as a whole, may go to sleep. Each peripheral has its own 8-bit idle countdown, loaded from a programmed value. Any activity seen by that peripheral reloads the countdown: a register access, an interrupt or an external input event, all reported to this block as a single-cycle pulse. The countdown falls by one on every time-base unit. When it runs out, the peripheral's sleep flag is raised.

Once every peripheral is asleep, a second, chip-wide standby countdown is loaded. When that countdown runs out, the chip sleep flag is raised. The time-base unit is one second or one minute, chosen by one shared select input. The minute is made inside the block by counting 60 pulses of a free-running seconds tick. A programmed count of zero freezes the current state of the timer it belongs to. Power-management enables gate both tiers.

Top module: `idle_pwrdn_ctrl`

## Requirements
- R1: After reset, all peripheral sleep flags and the chip sleep flag are 0, and the minute divider starts from zero.
- R2: With both enables set and a count L (1 to 255), a peripheral's sleep flag rises at the clock edge of the L-th time-base tick after its last reload, and not before. A rise always coincides with a seconds tick.
- R3: An activity pulse puts its peripheral in the working state (flag 0) at the next clock edge and reloads its countdown from the programmed count.
- R4: When activity and a time-base tick arrive in the same cycle, the reload wins: L further ticks are needed before that peripheral sleeps.
- R5: While a peripheral's programmed count is 0 and it sees no activity, its sleep flag keeps its value, whether that is working (0) or sleeping (1).
- R6: With the select at 0 every seconds tick is a time-base tick. With the select at 1 only every 60th seconds tick counted since reset (the 60th, 120th, ...) is a time-base tick.
- R7: While the chip enable or a peripheral's own enable is 0, that peripheral's flag is 0 from the next edge and its countdown holds the programmed count. When the enable returns, a full count of L ticks is needed.
- R8: Once all four peripheral flags are 1, the standby countdown loads the chip count at the next edge. The chip sleep flag rises on the chip-count-th time-base tick after that, and a rise always coincides with a seconds tick.
- R9: Activity on any peripheral clears the chip sleep flag at the next edge and aborts a running standby countdown. The next arming starts again from the full chip count.
- R10: While all peripherals are asleep, the chip count is 0 and there is no activity, the chip sleep flag keeps its value.
- R11: While the chip enable is 0, the chip sleep flag is 0 from the next edge.
- R12: The chip sleep flag only rises when all peripheral flags were 1 in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | Single-cycle seconds strobe |
| min_sel_i | input | 1 | Time base: 0 = seconds, 1 = minutes |
| chip_pm_en_i | input | 1 | Chip-wide power-management enable |
| periph_pm_en_i | input | NUM_PERIPH | Per-peripheral power-management enable |
| activity_i | input | NUM_PERIPH | Per-peripheral activity pulse |
| periph_count_i | input | NUM_PERIPH*CNT_W | Programmed idle counts; peripheral i at bits [i*CNT_W +: CNT_W] |
| chip_count_i | input | CNT_W | Programmed standby count |
| periph_sleep_o | output | NUM_PERIPH | Per-peripheral sleep flag, 1 = sleeping |
| chip_sleep_o | output | 1 | Chip sleep flag, 1 = sleeping |

## Verification
The bound checker checks on every cycle the properties that hold at all times:
- activity or a missing enable forces the working state;
- a zero count freezes the flag;
- any sleep transition lands on a seconds tick;
- the chip flag rises only after all peripherals were asleep.

Only the bench scenarios can show the exact countdown lengths:
- the L-th-tick expiry swept over several counts on every peripheral;
- reload priority over a coincident tick;
- the full restart of the standby countdown after an abort;
- the minute divider's phase counted from reset.

// File: rtl/pd_pkg.sv
package pd_pkg;
   typedef enum logic {
      PD_WORK  = 1'b0,
      PD_SLEEP = 1'b1
   } pd_state_e;
endpackage

// File: rtl/pd_timebase.sv
module pd_timebase #(
   parameter int unsigned SEC_PER_MIN = 60
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sec_tick_i,
   input  logic min_sel_i,
   output logic unit_tick_o
);
   logic min_tick;

   generate
      if (SEC_PER_MIN <= 1) begin : g_nodiv
         assign min_tick = sec_tick_i;
      end else begin : g_div
         localparam int unsigned DW = $clog2(SEC_PER_MIN);
         localparam logic [DW-1:0] LAST = DW'(SEC_PER_MIN - 1);
         logic [DW-1:0] sec_cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sec_cnt_q <= '0;
            end else if (sec_tick_i) begin
               sec_cnt_q <= (sec_cnt_q == LAST) ? '0 : sec_cnt_q + DW'(1);
            end
         end

         assign min_tick = sec_tick_i && (sec_cnt_q == LAST);
      end
   endgenerate

   assign unit_tick_o = min_sel_i ? min_tick : sec_tick_i;
endmodule

// File: rtl/pd_idle_timer.sv
module pd_idle_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             activity_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             sleep_o
);
   pd_pkg::pd_state_e state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              counting;

   // a zero load freezes the state; only a working timer counts
   assign counting = (load_i != '0) && tick_i && (state_q == pd_pkg::PD_WORK);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         state_q <= pd_pkg::PD_WORK;
      end else if (!enable_i || activity_i) begin
         cnt_q   <= load_i;
         state_q <= pd_pkg::PD_WORK;
      end else if (counting) begin
         if (cnt_q <= CNT_W'(1)) begin
            cnt_q   <= '0;
            state_q <= pd_pkg::PD_SLEEP;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign sleep_o = (state_q == pd_pkg::PD_SLEEP);
endmodule

// File: rtl/pd_standby_timer.sv
module pd_standby_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             any_act_i,
   input  logic             all_asleep_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             sleep_o
);
   pd_pkg::pd_state_e state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         state_q <= pd_pkg::PD_WORK;
      end else if (!enable_i || any_act_i || !all_asleep_i) begin
         cnt_q   <= load_i;
         armed_q <= 1'b0;
         state_q <= pd_pkg::PD_WORK;
      end else if (load_i == '0) begin
         cnt_q <= cnt_q;                 // frozen
      end else if (!armed_q) begin
         cnt_q   <= load_i;              // arm on entry to all-asleep
         armed_q <= 1'b1;
      end else if (tick_i && state_q == pd_pkg::PD_WORK) begin
         if (cnt_q <= CNT_W'(1)) begin
            cnt_q   <= '0;
            state_q <= pd_pkg::PD_SLEEP;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign sleep_o = (state_q == pd_pkg::PD_SLEEP);
endmodule

// File: rtl/idle_pwrdn_ctrl.sv
module idle_pwrdn_ctrl #(
   parameter int unsigned NUM_PERIPH  = 4,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SEC_PER_MIN = 60
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        sec_tick_i,
   input  logic                        min_sel_i,
   input  logic                        chip_pm_en_i,
   input  logic [NUM_PERIPH-1:0]       periph_pm_en_i,
   input  logic [NUM_PERIPH-1:0]       activity_i,
   input  logic [NUM_PERIPH*CNT_W-1:0] periph_count_i,
   input  logic [CNT_W-1:0]            chip_count_i,
   output logic [NUM_PERIPH-1:0]       periph_sleep_o,
   output logic                        chip_sleep_o
);
   initial begin
      assert (NUM_PERIPH >= 1) else $fatal(1, "NUM_PERIPH must be at least 1");
      assert (CNT_W >= 2) else $fatal(1, "CNT_W must be at least 2");
      assert (SEC_PER_MIN >= 1) else $fatal(1, "SEC_PER_MIN must be at least 1");
   end

   logic unit_tick;

   pd_timebase #(.SEC_PER_MIN(SEC_PER_MIN)) u_timebase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sec_tick_i (sec_tick_i),
      .min_sel_i  (min_sel_i),
      .unit_tick_o(unit_tick)
   );

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
         pd_idle_timer #(.CNT_W(CNT_W)) u_idle (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .enable_i   (chip_pm_en_i && periph_pm_en_i[i]),
            .activity_i (activity_i[i]),
            .tick_i     (unit_tick),
            .load_i     (periph_count_i[i*CNT_W +: CNT_W]),
            .sleep_o    (periph_sleep_o[i])
         );
      end
   endgenerate

   pd_standby_timer #(.CNT_W(CNT_W)) u_standby (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .enable_i     (chip_pm_en_i),
      .any_act_i    (|activity_i),
      .all_asleep_i (&periph_sleep_o),
      .tick_i       (unit_tick),
      .load_i       (chip_count_i),
      .sleep_o      (chip_sleep_o)
   );
endmodule

// File: rtl/idle_pwrdn_ctrl_chk.sv
module idle_pwrdn_ctrl_chk #(
   parameter int unsigned NUM_PERIPH = 4,
   parameter int unsigned CNT_W      = 8
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        sec_tick_i,
   input logic                        chip_pm_en_i,
   input logic [NUM_PERIPH-1:0]       periph_pm_en_i,
   input logic [NUM_PERIPH-1:0]       activity_i,
   input logic [NUM_PERIPH*CNT_W-1:0] periph_count_i,
   input logic [CNT_W-1:0]            chip_count_i,
   input logic [NUM_PERIPH-1:0]       periph_sleep_o,
   input logic                        chip_sleep_o
);
   logic [NUM_PERIPH-1:0] en_vec;
   assign en_vec = periph_pm_en_i & {NUM_PERIPH{chip_pm_en_i}};

   assert_wake_on_activity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |activity_i |=> (periph_sleep_o & $past(activity_i)) == '0);

   assert_disabled_works_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_vec != {NUM_PERIPH{1'b1}} |=> (periph_sleep_o & ~$past(en_vec)) == '0);

   assert_chip_disable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chip_pm_en_i |=> !chip_sleep_o);

   assert_chip_rise_all_asleep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chip_sleep_o) |-> $past(&periph_sleep_o));

   assert_chip_rise_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chip_sleep_o) |-> $past(sec_tick_i));

   assert_chip_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chip_pm_en_i && !(|activity_i) && chip_count_i == '0 && (&periph_sleep_o))
      |=> $stable(chip_sleep_o));

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_chk
         assert_periph_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_vec[i] && !activity_i[i] && periph_count_i[i*CNT_W +: CNT_W] == '0)
            |=> $stable(periph_sleep_o[i]));

         assert_periph_rise_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(periph_sleep_o[i]) |-> $past(sec_tick_i));
      end
   endgenerate
endmodule

bind idle_pwrdn_ctrl idle_pwrdn_ctrl_chk #(
   .NUM_PERIPH(NUM_PERIPH),
   .CNT_W     (CNT_W)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .sec_tick_i     (sec_tick_i),
   .chip_pm_en_i   (chip_pm_en_i),
   .periph_pm_en_i (periph_pm_en_i),
   .activity_i     (activity_i),
   .periph_count_i (periph_count_i),
   .chip_count_i   (chip_count_i),
   .periph_sleep_o (periph_sleep_o),
   .chip_sleep_o   (chip_sleep_o)
);

// File: tb/idle_pwrdn_ctrl_tb.sv
module idle_pwrdn_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sec_tick;
   logic          min_sel;
   logic          chip_en;
   logic [NP-1:0] periph_en;
   logic [NP-1:0] activity;
   logic [NP*CW-1:0] periph_count;
   logic [CW-1:0] chip_count;
   logic [NP-1:0] periph_sleep;
   logic          chip_sleep;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idle_pwrdn_ctrl #(.NUM_PERIPH(NP), .CNT_W(CW), .SEC_PER_MIN(60)) u_dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .sec_tick_i     (sec_tick),
      .min_sel_i      (min_sel),
      .chip_pm_en_i   (chip_en),
      .periph_pm_en_i (periph_en),
      .activity_i     (activity),
      .periph_count_i (periph_count),
      .chip_count_i   (chip_count),
      .periph_sleep_o (periph_sleep),
      .chip_sleep_o   (chip_sleep)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) sec_tick = 1'b1;
         @(negedge clk) sec_tick = 1'b0;
      end
   endtask

   task automatic poke(input logic [NP-1:0] m);
      @(negedge clk) activity = m;
      @(negedge clk) activity = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cnt(input int p, input logic [CW-1:0] v);
      periph_count[p*CW +: CW] = v;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      sec_tick = 0; min_sel = 0; chip_en = 0; periph_en = '0; activity = '0;
      periph_count = '0; chip_count = '0;
      do_reset();
      // R1 reset state
      chk("R1 periph flags", 32'(periph_sleep), 0);
      chk("R1 chip flag", 32'(chip_sleep), 0);

      chip_en = 1'b1; periph_en = '1;
      tick(5);
      chk("R5 zero count stays working", 32'(periph_sleep), 0);

      // R2 / R3 sweep over counts and peripherals
      for (int p = 0; p < NP; p++) begin
         for (int L = 1; L <= 6; L++) begin
            set_cnt(p, CW'(L));
            poke(NP'(1) << p);
            if (L > 1) begin
               tick(L - 1);
               chk("R2 awake before last tick", 32'(periph_sleep[p]), 0);
            end
            tick(1);
            chk("R2 asleep on L-th tick", 32'(periph_sleep), 32'(NP'(1) << p));
            chk("R12 chip stays awake", 32'(chip_sleep), 0);
            poke(NP'(1) << p);
            chk("R3 activity wakes", 32'(periph_sleep[p]), 0);
         end
         set_cnt(p, 0);
      end

      // R4 reload beats a coincident tick
      set_cnt(2, 3);
      poke(4'b0100);
      tick(2);
      @(negedge clk) begin activity = 4'b0100; sec_tick = 1'b1; end
      @(negedge clk) begin activity = '0; sec_tick = 1'b0; end
      tick(2);
      chk("R4 reload wins, still awake", 32'(periph_sleep[2]), 0);
      tick(1);
      chk("R4 asleep after full count", 32'(periph_sleep[2]), 1);

      // R5 zero count freezes sleeping
      set_cnt(2, 0);
      tick(4);
      chk("R5 zero count stays asleep", 32'(periph_sleep[2]), 1);
      poke(4'b0100);
      chk("R3 wake with zero count", 32'(periph_sleep[2]), 0);

      // R7 per-peripheral enable
      set_cnt(1, 2);
      poke(4'b0010);
      tick(2);
      chk("R7 precondition asleep", 32'(periph_sleep[1]), 1);
      periph_en[1] = 1'b0;
      idle(1);
      chk("R7 disable forces working", 32'(periph_sleep[1]), 0);
      tick(3);
      chk("R7 no countdown while disabled", 32'(periph_sleep[1]), 0);
      periph_en[1] = 1'b1;
      tick(1);
      chk("R7 full count after re-enable", 32'(periph_sleep[1]), 0);
      tick(1);
      chk("R7 asleep after full count", 32'(periph_sleep[1]), 1);
      set_cnt(1, 0);
      poke(4'b0010);

      // R8 chip standby
      for (int p = 0; p < NP; p++) set_cnt(p, 2);
      chip_count = 3;
      poke(4'b1111);
      tick(2);
      chk("R8 all asleep", 32'(periph_sleep), 32'hF);
      chk("R8 chip not yet", 32'(chip_sleep), 0);
      idle(2);
      tick(2);
      chk("R8 chip awake before count", 32'(chip_sleep), 0);
      tick(1);
      chk("R8 chip asleep on count", 32'(chip_sleep), 1);

      // R9 activity wakes the chip
      poke(4'b0010);
      chk("R9 chip woken", 32'(chip_sleep), 0);
      chk("R9 only p1 woken", 32'(periph_sleep), 32'hD);
      tick(1);
      chk("R12 no chip sleep with p1 awake", 32'(chip_sleep), 0);
      tick(1);
      idle(2);
      tick(2);
      chk("R9 rearmed, not yet", 32'(chip_sleep), 0);
      poke(4'b0001);
      tick(2);
      idle(2);
      tick(2);
      chk("R9 aborted count restarts", 32'(chip_sleep), 0);
      tick(1);
      chk("R9 chip asleep after full count", 32'(chip_sleep), 1);

      // R10 zero chip count freezes
      chip_count = 0;
      tick(5);
      chk("R10 chip stays asleep", 32'(chip_sleep), 1);
      poke(4'b0001);
      tick(2);
      idle(2);
      tick(6);
      chk("R10 chip stays awake", 32'(chip_sleep), 0);

      // R11 chip enable
      chip_count = 3;
      idle(2);
      tick(3);
      chk("R11 precondition chip asleep", 32'(chip_sleep), 1);
      chip_en = 1'b0;
      idle(1);
      chk("R11 chip flag cleared", 32'(chip_sleep), 0);
      chk("R11 periph flags cleared", 32'(periph_sleep), 0);
      tick(5);
      chk("R11 stays cleared", 32'(chip_sleep), 0);
      chip_en = 1'b1;

      // R6 minute time base, phase counted from reset
      for (int p = 0; p < NP; p++) set_cnt(p, 0);
      set_cnt(0, 2);
      chip_count = 0;
      min_sel = 1'b1;
      do_reset();
      poke(4'b0001);
      tick(60);
      chk("R6 one minute not enough", 32'(periph_sleep[0]), 0);
      tick(59);
      chk("R6 awake before second minute", 32'(periph_sleep[0]), 0);
      tick(1);
      chk("R6 asleep after two minutes", 32'(periph_sleep[0]), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule